// File: doc/BRIEF.md
# Video parameter list parser

This block walks a stream of 32-bit words that describe a display mode. It takes one word per valid/ready handshake. The first word picks one of two list formats. The second word is a base mode number. Register parameter words follow until a terminator word of all ones. In the extended format, a trailer of tagged parameters follows, and a second all-ones word ends that trailer. Tag 0 in the trailer carries a requested pixel rate in kHz. Tag 1 carries the sync polarity bits.

Register parameter words are passed to an output port one cycle after they are accepted. A register word whose top byte is 0xE0 is the controller control word. It is captured, and its two divider bits are replaced when the list also requests a pixel rate. When the list ends, the block pulses `done` for one cycle. At that point the summary outputs hold the base mode, the rate flag and value, the polarity, the captured control word and a sticky error flag.

The parser is one state machine with five states:
- `ST_TYPE`: waits for the format word. Any accepted word moves it to `ST_MODE`.
- `ST_MODE`: takes the base mode word, then moves to `ST_BODY`.
- `ST_BODY`: passes register words through. An all-ones word moves it to `ST_EXT` in the extended format, or to `ST_DONE` otherwise.
- `ST_EXT`: decodes tagged words. An all-ones word moves it to `ST_DONE`.
- `ST_DONE`: lasts exactly one cycle, with `in_ready` low. It always returns to `ST_TYPE`.

Top module: `vlist_parser`

## Requirements
- R1: Synchronous reset state. After `rst` is sampled high, the outputs are `in_ready`=1, `done`=0, `reg_valid`=0, `err`=0, `rate_present`=0, `sync_pol`=0 and `ctrl_seen`=0, and the parser waits for a format word.
- R2: Register pass-through. In the main body, every accepted word other than all ones appears on `reg_data`, with `reg_valid` high in the cycle after acceptance. The format word, the base mode word, terminators and extended words never raise `reg_valid`.
- R3: End of list. Accepting the terminator that ends a list raises `done` for exactly the next cycle, and `in_ready` is low during that cycle. In format 0 (format word value 0), the list ends at the first all-ones word and `rate_present` stays 0.
- R4: Extended format. With a format word of value 1, the words after the first all-ones word are extended parameters. They are not passed through, and a second all-ones word ends the list.
- R5: Pixel rate. An extended word with bits 31..24 equal to 0 sets `rate_present`=1 and loads bits 23..0 into `rate_khz`. If several such words arrive, the last one wins.
- R6: Sync polarity. An extended word with bits 31..24 equal to 1 and bits 23..2 all zero loads bits 1..0 into `sync_pol`. Bit 0 set means horizontal sync is negative, and bit 1 set means vertical sync is negative. If no such word arrives, `sync_pol` is 0. The last valid word wins.
- R7: Control word. A main-body word with bits 31..24 equal to 0xE0 sets `ctrl_seen` and is held on `ctrl_word`. While `rate_present` is 1, bits 1..0 of `ctrl_word` read as `OVR_DIV` (default 2'b00).
- R8: Errors. Any of the following sets `err`, which then stays set until reset:
  - a format word other than 0 or 1, in which case the list is then parsed as format 0;
  - a tag-1 word with any of bits 23..2 set, in which case `sync_pol` is left unchanged;
  - an extended tag above 1, in which case the word is otherwise ignored.
- R9: Base mode. `base_mode` holds the second word of the most recent list.
- R10: New list. Accepting a format word clears `rate_present`, `rate_khz`, `sync_pol`, `ctrl_seen` and `ctrl_word`, but not `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input list word |
| in_ready | output | 1 | Parser can take a word |
| reg_valid | output | 1 | Passed-through register word valid |
| reg_data | output | 32 | Passed-through register word |
| done | output | 1 | One-cycle end-of-list pulse |
| base_mode | output | 32 | Base mode of the latest list |
| rate_present | output | 1 | A pixel rate was requested |
| rate_khz | output | 24 | Requested pixel rate in kHz |
| sync_pol | output | 2 | Bit 0 horizontal negative, bit 1 vertical negative |
| ctrl_seen | output | 1 | A control word was captured |
| ctrl_word | output | 32 | Captured control word, divider bits possibly overridden |
| err | output | 1 | Sticky format error |

## Verification
Two functions can land in the same cycle: capturing a pixel rate and overriding the divider bits of an already captured control word. Both must be visible when `done` rises. The bench provokes this by sending the rate word back to back with the closing terminator, so the override has no spare cycle. It then judges `ctrl_word`, `rate_khz` and `rate_present` in the very cycle `done` is high, against values derived from the list it sent.

// File: rtl/vlist_pkg.sv
package vlist_pkg;
    localparam int WORD_W = 32;
    localparam int TAG_W  = 8;
    localparam int RATE_W = 24;
    localparam int POL_W  = 2;
    localparam int DIV_W  = 2;

    localparam logic [TAG_W-1:0] TAG_RATE = 8'h00;
    localparam logic [TAG_W-1:0] TAG_POL  = 8'h01;
    localparam logic [TAG_W-1:0] CTRL_TAG = 8'hE0;

    typedef enum logic [2:0] {
        ST_TYPE,
        ST_MODE,
        ST_BODY,
        ST_EXT,
        ST_DONE
    } state_e;
endpackage

// File: rtl/vlist_classify.sv
module vlist_classify
    import vlist_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int TW = TAG_W,
    parameter int RW = RATE_W,
    parameter int PW = POL_W
) (
    input  logic [W-1:0] word,
    output logic         is_term,
    output logic         is_ctrl,
    output logic         is_rate,
    output logic         is_pol,
    output logic         pol_ok,
    output logic         bad_tag
);
    localparam int TAG_LSB = W - TW;

    logic [TW-1:0] tag;

    always_comb begin
        tag     = word[W-1:TAG_LSB];
        is_term = &word;
        is_ctrl = (tag == CTRL_TAG);
        is_rate = (tag == TAG_RATE);
        is_pol  = (tag == TAG_POL);
        pol_ok  = (word[RW-1:PW] == '0);
        bad_tag = !is_rate && !is_pol;
    end
endmodule

// File: rtl/vlist_ext_store.sv
module vlist_ext_store #(
    parameter int RW = 24,
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          we_rate,
    input  logic          we_pol,
    input  logic [RW-1:0] rate_in,
    input  logic [PW-1:0] pol_in,
    output logic          rate_present,
    output logic [RW-1:0] rate_khz,
    output logic [PW-1:0] sync_pol
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rate_present <= 1'b0;
            rate_khz     <= '0;
            sync_pol     <= '0;
        end else begin
            if (we_rate) begin
                rate_present <= 1'b1;
                rate_khz     <= rate_in;
            end
            if (we_pol) begin
                sync_pol <= pol_in;
            end
        end
    end
endmodule

// File: rtl/vlist_ctrl_capture.sv
module vlist_ctrl_capture #(
    parameter int            W       = 32,
    parameter int            DW      = 2,
    parameter logic [DW-1:0] OVR_DIV = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         we,
    input  logic [W-1:0] word,
    input  logic         rate_present,
    output logic         ctrl_seen,
    output logic [W-1:0] ctrl_word
);
    logic [W-1:0] raw_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ctrl_seen <= 1'b0;
            raw_q     <= '0;
        end else if (we) begin
            ctrl_seen <= 1'b1;
            raw_q     <= word;
        end
    end

    always_comb begin
        ctrl_word = raw_q;
        if (rate_present) begin
            ctrl_word[DW-1:0] = OVR_DIV;
        end
    end
endmodule

// File: rtl/vlist_parser.sv
module vlist_parser
    import vlist_pkg::*;
#(
    parameter logic [DIV_W-1:0] OVR_DIV = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              reg_valid,
    output logic [WORD_W-1:0] reg_data,
    output logic              done,
    output logic [WORD_W-1:0] base_mode,
    output logic              rate_present,
    output logic [RATE_W-1:0] rate_khz,
    output logic [POL_W-1:0]  sync_pol,
    output logic              ctrl_seen,
    output logic [WORD_W-1:0] ctrl_word,
    output logic              err
);
    state_e state_q, state_d;
    logic   ext_fmt_q;
    logic   accept;
    logic   is_term, is_ctrl, is_rate, is_pol, pol_ok, bad_tag;
    logic   clr, ext_word, body_word;

    vlist_classify #(
        .W (WORD_W),
        .TW(TAG_W),
        .RW(RATE_W),
        .PW(POL_W)
    ) u_cls (
        .word   (in_data),
        .is_term(is_term),
        .is_ctrl(is_ctrl),
        .is_rate(is_rate),
        .is_pol (is_pol),
        .pol_ok (pol_ok),
        .bad_tag(bad_tag)
    );

    always_comb begin
        accept    = in_valid && in_ready;
        clr       = accept && (state_q == ST_TYPE);
        body_word = accept && (state_q == ST_BODY) && !is_term;
        ext_word  = accept && (state_q == ST_EXT) && !is_term;
    end

    vlist_ext_store #(
        .RW(RATE_W),
        .PW(POL_W)
    ) u_ext (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .we_rate     (ext_word && is_rate),
        .we_pol      (ext_word && is_pol && pol_ok),
        .rate_in     (in_data[RATE_W-1:0]),
        .pol_in      (in_data[POL_W-1:0]),
        .rate_present(rate_present),
        .rate_khz    (rate_khz),
        .sync_pol    (sync_pol)
    );

    vlist_ctrl_capture #(
        .W      (WORD_W),
        .DW     (DIV_W),
        .OVR_DIV(OVR_DIV)
    ) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr),
        .we          (body_word && is_ctrl),
        .word        (in_data),
        .rate_present(rate_present),
        .ctrl_seen   (ctrl_seen),
        .ctrl_word   (ctrl_word)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_TYPE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TYPE: if (accept) state_d = ST_MODE;
            ST_MODE: if (accept) state_d = ST_BODY;
            ST_BODY: if (accept && is_term) state_d = ext_fmt_q ? ST_EXT : ST_DONE;
            ST_EXT:  if (accept && is_term) state_d = ST_DONE;
            ST_DONE: state_d = ST_TYPE;
            default: state_d = ST_TYPE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        in_ready = 1'b1;
        done     = 1'b0;
        unique case (state_q)
            ST_DONE: begin
                in_ready = 1'b0;
                done     = 1'b1;
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ext_fmt_q <= 1'b0;
            base_mode <= '0;
            reg_valid <= 1'b0;
            reg_data  <= '0;
            err       <= 1'b0;
        end else begin
            reg_valid <= body_word;
            if (body_word) reg_data <= in_data;
            if (clr) begin
                ext_fmt_q <= (in_data == WORD_W'(1));
                if (in_data > WORD_W'(1)) err <= 1'b1;
            end
            if (accept && state_q == ST_MODE) base_mode <= in_data;
            if (ext_word && (bad_tag || (is_pol && !pol_ok))) err <= 1'b1;
        end
    end
endmodule

// File: rtl/vlist_parser_chk.sv
module vlist_parser_chk #(
    parameter int DW = 2,
    parameter logic [DW-1:0] OVR_DIV = '0
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic        reg_valid,
    input logic        done,
    input logic        rate_present,
    input logic [23:0] rate_khz,
    input logic        ctrl_seen,
    input logic [DW-1:0] ctrl_div,
    input logic        err
);
    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

    // R3
    done_stall_chk: assert property (@(posedge clk) disable iff (rst) done |-> !in_ready);

    // R3
    resume_chk: assert property (@(posedge clk) disable iff (rst) done |=> in_ready);

    // R2
    reg_src_chk: assert property (@(posedge clk) disable iff (rst) reg_valid |-> $past(in_valid && in_ready));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst) err |=> err);

    // R7
    ovr_div_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ctrl_seen && rate_present) |-> (ctrl_div == OVR_DIV));

    // R10
    rate_idle_chk: assert property (@(posedge clk) disable iff (rst) !rate_present |-> (rate_khz == '0));
endmodule

bind vlist_parser vlist_parser_chk #(
    .DW     (vlist_pkg::DIV_W),
    .OVR_DIV(OVR_DIV)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .reg_valid   (reg_valid),
    .done        (done),
    .rate_present(rate_present),
    .rate_khz    (rate_khz),
    .ctrl_seen   (ctrl_seen),
    .ctrl_div    (ctrl_word[vlist_pkg::DIV_W-1:0]),
    .err         (err)
);

// File: tb/sim_vlist_parser.sv
`timescale 1ns/1ps
module sim_vlist_parser;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, reg_valid, done, rate_present, ctrl_seen, err;
    logic [31:0] reg_data, base_mode, ctrl_word;
    logic [23:0] rate_khz;
    logic [1:0]  sync_pol;

    int checks = 0;
    int fails  = 0;

    localparam logic [31:0] TERM = 32'hFFFF_FFFF;

    always #10 clk = ~clk;

    vlist_parser u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .reg_valid(reg_valid), .reg_data(reg_data),
        .done(done), .base_mode(base_mode), .rate_present(rate_present),
        .rate_khz(rate_khz), .sync_pol(sync_pol), .ctrl_seen(ctrl_seen),
        .ctrl_word(ctrl_word), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the word is taken.
    task automatic send(input logic [31:0] w);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0;
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 in_ready", 32'(in_ready), 32'd1);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 reg_valid", 32'(reg_valid), 32'd0);
        chk("R1 err", 32'(err), 32'd0);
        chk("R1 rate_present", 32'(rate_present), 32'd0);
        chk("R1 sync_pol", 32'(sync_pol), 32'd0);
        chk("R1 ctrl_seen", 32'(ctrl_seen), 32'd0);
    endtask

    task automatic t_type0();
        send(32'd0);
        chk("R2 no pass of format word", 32'(reg_valid), 32'd0);
        send(32'd5);
        chk("R2 no pass of mode word", 32'(reg_valid), 32'd0);
        send(32'h0000_1234);
        chk("R2 reg_valid", 32'(reg_valid), 32'd1);
        chk("R2 reg_data", reg_data, 32'h0000_1234);
        send(32'hE000_0002);
        chk("R2 reg_data ctrl", reg_data, 32'hE000_0002);
        send(TERM);
        idle();
        chk("R3 done", 32'(done), 32'd1);
        chk("R3 ready low", 32'(in_ready), 32'd0);
        chk("R3 rate absent", 32'(rate_present), 32'd0);
        chk("R2 term not passed", 32'(reg_valid), 32'd0);
        chk("R9 base_mode", base_mode, 32'd5);
        chk("R7 ctrl_word raw", ctrl_word, 32'hE000_0002);
        chk("R7 ctrl_seen", 32'(ctrl_seen), 32'd1);
        chk("R6 default pol", 32'(sync_pol), 32'd0);
        @(negedge clk);
        chk("R3 done one cycle", 32'(done), 32'd0);
    endtask

    task automatic t_type1_full();
        send(32'd1);
        send(32'd7);
        send(32'hE000_0003);
        send(32'h0000_ABCD);
        send(TERM);
        chk("R4 not done after first term", 32'(done), 32'd0);
        send(32'h0000_6257);
        chk("R4 ext not passed", 32'(reg_valid), 32'd0);
        chk("R5 rate first", 32'(rate_khz), 32'h0000_6257);
        send(32'h0100_0001);
        chk("R6 hsync neg", 32'(sync_pol), 32'd1);
        send(32'h0100_0003);
        send(32'h0000_1F40);
        send(TERM);
        idle();
        chk("R4 done", 32'(done), 32'd1);
        chk("R5 last rate wins", 32'(rate_khz), 32'h0000_1F40);
        chk("R5 rate_present", 32'(rate_present), 32'd1);
        chk("R6 last pol wins", 32'(sync_pol), 32'd3);
        chk("R7 divider overridden", ctrl_word, 32'hE000_0000);
        chk("R9 base_mode", base_mode, 32'd7);
        chk("R8 no err", 32'(err), 32'd0);
    endtask

    task automatic t_type1_bare();
        send(32'd1);
        send(32'd2);
        send(32'hE000_0001);
        send(TERM);
        send(TERM);
        idle();
        chk("R4 done empty trailer", 32'(done), 32'd1);
        chk("R10 rate cleared", 32'(rate_present), 32'd0);
        chk("R10 pol cleared", 32'(sync_pol), 32'd0);
        chk("R7 ctrl kept raw", ctrl_word, 32'hE000_0001);
    endtask

    task automatic t_errors();
        send(32'd1);
        send(32'd3);
        send(TERM);
        send(32'h0100_0004);
        chk("R8 bad pol err", 32'(err), 32'd1);
        chk("R8 pol unchanged", 32'(sync_pol), 32'd0);
        send(32'h0500_0000);
        send(TERM);
        idle();
        chk("R8 bad tag ignored", 32'(rate_present), 32'd0);
        chk("R8 err done", 32'(done), 32'd1);
        @(negedge clk);
        chk("R8 err sticky", 32'(err), 32'd1);
        do_reset();
        chk("R1 err cleared", 32'(err), 32'd0);
        send(32'd2);
        chk("R8 bad type err", 32'(err), 32'd1);
        send(32'd1);
        send(32'h0000_0055);
        send(TERM);
        idle();
        chk("R8 bad type parsed as format 0", 32'(done), 32'd1);
        chk("R10 ctrl cleared", 32'(ctrl_seen), 32'd0);
    endtask

    bit finished = 1'b0;

    initial begin
        @(negedge clk);
        t_reset();
        t_type0();
        t_type1_full();
        t_type1_bare();
        t_errors();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule